// File: doc/BRIEF.md
# PLL Mode and Recalibration Controller

This block is the digital sequencer that sits in front of a phase-locked loop. Software writes a 3-bit mode code; the controller turns it into the analog enable, output-bypass and low-power pins. It also qualifies the loop's lock indication and reports whether the loop is in a bypass flavour or locked. Three bypass flavours exist. Multiplier/divider bypass powers the loop down and clears the multiplier setting. Low-power idle bypass powers it down and raises the low-power pin. Fast-relock idle bypass keeps the loop running so that a later lock request completes sooner.

When drift guarding is enabled and the loop raises its recalibration flag while locked, the controller relocks the loop without any help from software. It forces the output back to bypass until lock is qualified again, and then pulses a done strobe. A mode code written while a lock or relock is under way is stored and acted on once that sequence ends. A synchronous warm reset returns the controller to multiplier/divider bypass and rewrites the mode field to match.

Top module: `pll_mode_ctrl`

## Requirements
- R1: After cold reset, mode_q reads 4, mult_q is 0, and the pins show multiplier/divider bypass: pll_en=0, pll_byp=1, pll_lp=0, st_bypass=1, st_locked=0.
- R2: With no sequence running, an accepted write takes effect at the next clock edge, with these pins: code 4 gives en=0 byp=1 lp=0; code 5 gives en=0 byp=1 lp=1; code 6 gives en=1 byp=1 lp=0. In all three, st_bypass=1. Code 7 from a bypass state starts locking, with en=1, byp=1, st_bypass=0 and st_locked=0. Code 7 while already locked changes nothing.
- R3: A write of code 0 to 3 leaves mode_q, the state and every output pin unchanged.
- R4: A warm reset pulse sets mode_q to 4, mult_q to 0 and the pins to multiplier/divider bypass at the next edge, from any state.
- R5: mult_q loads mult_wdata on mult_wr. Entering multiplier/divider bypass from another state clears mult_q to 0, and the clear takes priority over a load in the same cycle.
- R6: While locking, st_locked and pll_byp=0 appear at the edge where lock_in is sampled high for the second consecutive cycle. A lock_in pulse lasting one cycle never locks.
- R7: With drift_en=1, a recalibration flag sampled while locked clears st_locked and sets pll_byp=1, pll_en=1 at the next edge. On requalified lock, st_locked returns and recal_done is high for exactly one cycle.
- R8: A recalibration flag has no effect when drift_en=0, and none in any bypass state.
- R9: A valid code written during locking or relocking updates mode_q at once. The state change it requests is applied one edge after st_locked is reached.
- R10: If a valid write and a recalibration flag (drift_en=1) arrive in the same locked cycle, the write is acted on and no relock starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous cold reset, active low |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| mode_wr | input | 1 | Mode field write strobe |
| mode_wdata | input | 3 | Mode code to write |
| drift_en | input | 1 | Enables automatic relock on a recalibration flag |
| mult_wr | input | 1 | Multiplier write strobe |
| mult_wdata | input | MULT_W | Multiplier value to write |
| lock_in | input | 1 | Lock indication from the loop |
| recal_in | input | 1 | Recalibration request flag from the loop |
| mode_q | output | 3 | Current mode field |
| mult_q | output | MULT_W | Current multiplier setting |
| pll_en | output | 1 | Loop analog enable |
| pll_byp | output | 1 | Output taken from the bypass clock |
| pll_lp | output | 1 | Low-power idle request |
| st_bypass | output | 1 | One of the three bypass modes is active |
| st_locked | output | 1 | Loop locked and qualified |
| recal_done | output | 1 | One-cycle strobe when a relock completes |

## Verification
Two functions can fall in the same locked cycle: a software mode write and the loop's recalibration flag. The bench raises both on one edge with drift_en set. It then requires that the fast-relock bypass pins appear, that st_locked stays low, and that recal_done never pulses. A second collision is a write that lands during a relock: the bench checks that the relock finishes and strobes recal_done first, and that the stored code takes hold on the following edge. An exhaustive sweep of every starting mode against every written code covers the reserved codes and the multiplier clear.

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl #(
  parameter int MULT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              mode_wr,
  input  logic [2:0]        mode_wdata,
  input  logic              drift_en,
  input  logic              mult_wr,
  input  logic [MULT_W-1:0] mult_wdata,
  input  logic              lock_in,
  input  logic              recal_in,
  output logic [2:0]        mode_q,
  output logic [MULT_W-1:0] mult_q,
  output logic              pll_en,
  output logic              pll_byp,
  output logic              pll_lp,
  output logic              st_bypass,
  output logic              st_locked,
  output logic              recal_done
);

  localparam logic [2:0] C_MNB = 3'd4;
  localparam logic [2:0] C_LPB = 3'd5;
  localparam logic [2:0] C_FRB = 3'd6;

  typedef enum logic [2:0] {S_MNB, S_LPB, S_FRB, S_LKG, S_LKD, S_RCL} st_t;

  st_t        st, nxt;
  logic       pend_v, lk_prev;
  logic [2:0] pend_c;

  wire wr_ok = mode_wr && mode_wdata[2];
  wire busy  = (st == S_LKG) || (st == S_RCL);
  wire qual  = busy && lock_in && lk_prev;

  function automatic st_t tgt(input logic [2:0] c, input st_t cur);
    case (c)
      C_MNB:   tgt = S_MNB;
      C_LPB:   tgt = S_LPB;
      C_FRB:   tgt = S_FRB;
      default: tgt = (cur == S_LKD) ? S_LKD : S_LKG;
    endcase
  endfunction

  always_comb begin
    nxt = st;
    if (busy) begin
      if (qual) nxt = S_LKD;
    end else if (st == S_LKD) begin
      if (wr_ok)                    nxt = tgt(mode_wdata, st);
      else if (pend_v)              nxt = tgt(pend_c, st);
      else if (drift_en && recal_in) nxt = S_RCL;
    end else if (wr_ok) begin
      nxt = tgt(mode_wdata, st);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_MNB;
      mode_q     <= C_MNB;
      mult_q     <= '0;
      pend_v     <= 1'b0;
      pend_c     <= '0;
      lk_prev    <= 1'b0;
      recal_done <= 1'b0;
    end else if (warm_rst) begin
      st         <= S_MNB;
      mode_q     <= C_MNB;
      mult_q     <= '0;
      pend_v     <= 1'b0;
      pend_c     <= '0;
      lk_prev    <= 1'b0;
      recal_done <= 1'b0;
    end else begin
      st <= nxt;
      if (wr_ok) mode_q <= mode_wdata;
      if (busy && wr_ok) begin
        pend_v <= 1'b1;
        pend_c <= mode_wdata;
      end else if (st == S_LKD) begin
        pend_v <= 1'b0;
      end
      lk_prev    <= busy && !qual && lock_in;
      recal_done <= (st == S_RCL) && qual;
      if (nxt == S_MNB && st != S_MNB) mult_q <= '0;
      else if (mult_wr)                mult_q <= mult_wdata;
    end
  end

  assign pll_en    = (st == S_FRB) || busy || (st == S_LKD);
  assign pll_byp   = (st != S_LKD);
  assign pll_lp    = (st == S_LPB);
  assign st_bypass = (st == S_MNB) || (st == S_LPB) || (st == S_FRB);
  assign st_locked = (st == S_LKD);

endmodule

// File: rtl/pll_mode_ctrl_chk.sv
module pll_mode_ctrl_chk #(
  parameter int MULT_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              warm_rst,
  input logic              mode_wr,
  input logic [2:0]        mode_wdata,
  input logic              drift_en,
  input logic              lock_in,
  input logic              recal_in,
  input logic [2:0]        mode_q,
  input logic [MULT_W-1:0] mult_q,
  input logic              pll_en,
  input logic              pll_byp,
  input logic              pll_lp,
  input logic              st_bypass,
  input logic              st_locked,
  input logic              recal_done
);

  p_warm_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> (mode_q == 3'd4) && st_bypass && !pll_en && (mult_q == '0));

  p_reserved_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !mode_wdata[2] && !warm_rst) |=> $stable(mode_q));

  p_mult_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pll_en) && !pll_lp) |-> (mult_q == '0));

  p_lock_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_locked) |-> ($past(lock_in) && $past(lock_in, 2)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    recal_done |-> st_locked ##1 !recal_done);

  p_drift_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_locked && $past(st_locked) && !drift_en && !mode_wr && !warm_rst) |=> st_locked);

  p_pin_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(st_bypass && st_locked)) && (!(pll_lp && pll_en)) && (st_locked == !pll_byp));

  p_recal_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_bypass && recal_in && !mode_wr && !warm_rst) |=> st_bypass);

endmodule

bind pll_mode_ctrl pll_mode_ctrl_chk #(.MULT_W(MULT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .mode_wr(mode_wr),
  .mode_wdata(mode_wdata), .drift_en(drift_en), .lock_in(lock_in),
  .recal_in(recal_in), .mode_q(mode_q), .mult_q(mult_q), .pll_en(pll_en),
  .pll_byp(pll_byp), .pll_lp(pll_lp), .st_bypass(st_bypass),
  .st_locked(st_locked), .recal_done(recal_done)
);

// File: tb/sim_pll_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pll_mode_ctrl;
  localparam int MW = 11;

  logic clk = 0, rst_n = 0, warm_rst = 0, mode_wr = 0, drift_en = 0, mult_wr = 0;
  logic recal_in = 0, lock_man = 0;
  logic [2:0] mode_wdata = 0;
  logic [MW-1:0] mult_wdata = 0;
  logic [2:0] mode_q;
  logic [MW-1:0] mult_q;
  logic pll_en, pll_byp, pll_lp, st_bypass, st_locked, recal_done, lock_in;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign lock_in = pll_en & lock_man;

  pll_mode_ctrl #(.MULT_W(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .drift_en(drift_en), .mult_wr(mult_wr),
    .mult_wdata(mult_wdata), .lock_in(lock_in), .recal_in(recal_in),
    .mode_q(mode_q), .mult_q(mult_q), .pll_en(pll_en), .pll_byp(pll_byp),
    .pll_lp(pll_lp), .st_bypass(st_bypass), .st_locked(st_locked),
    .recal_done(recal_done)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {en,byp,lp,st_bypass,st_locked}; s=0 means locking
  function automatic logic [4:0] pins(input logic [2:0] s);
    case (s)
      3'd4: pins = 5'b01010;
      3'd5: pins = 5'b01110;
      3'd6: pins = 5'b11010;
      3'd7: pins = 5'b10001;
      default: pins = 5'b11000;
    endcase
  endfunction

  function automatic logic [15:0] act_pins();
    act_pins = {11'd0, pll_en, pll_byp, pll_lp, st_bypass, st_locked};
  endfunction

  task automatic wr(input logic [2:0] c);
    mode_wdata = c; mode_wr = 1; step(); mode_wr = 0;
  endtask

  task automatic warm();
    warm_rst = 1; step(); warm_rst = 0;
  endtask

  task automatic lock_up();
    lock_man = 1; step(); step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    step(); rst_n = 1; step();
    chk("R1 mode", 16'(mode_q), 16'd4);
    chk("R1 mult", 16'(mult_q), 16'd0);
    chk("R1 pins", act_pins(), 16'(pins(3'd4)));

    for (int f = 4; f < 8; f++) begin
      for (int c = 0; c < 8; c++) begin
        warm(); lock_man = 0;
        chk("R4 mode", 16'(mode_q), 16'd4);
        wr(3'(f));
        if (f == 7) begin
          chk("R2 locking", act_pins(), 16'(pins(3'd0)));
          lock_up();
        end
        chk("R2 from", act_pins(), 16'(pins(3'(f))));
        mult_wdata = MW'(5 + f); mult_wr = 1; step(); mult_wr = 0;
        chk("R5 load", 16'(mult_q), 16'(5 + f));
        wr(3'(c));
        if (c < 4) begin
          chk("R3 mode", 16'(mode_q), 16'(f));
          chk("R3 pins", act_pins(), 16'(pins(3'(f))));
        end else begin
          chk("R2 mode", 16'(mode_q), 16'(c));
          if (c == 7 && f != 7) begin
            chk("R2 lock start", act_pins(), 16'(pins(3'd0)));
            lock_up();
          end
          chk("R2 pins", act_pins(), 16'(pins(3'(c))));
        end
        chk("R5 mult", 16'(mult_q), (c == 4 && f != 4) ? 16'd0 : 16'(5 + f));
      end
    end

    // R5 clear beats load in same cycle
    warm(); wr(3'd6);
    mode_wdata = 3'd4; mode_wr = 1; mult_wdata = 11'd9; mult_wr = 1;
    step(); mode_wr = 0; mult_wr = 0;
    chk("R5 clear priority", 16'(mult_q), 16'd0);

    // R6 single-cycle lock pulse
    warm(); lock_man = 0; wr(3'd7);
    lock_man = 1; step(); lock_man = 0; step(); step();
    chk("R6 glitch", 16'(st_locked), 16'd0);
    lock_man = 1; step();
    chk("R6 one cycle", 16'(st_locked), 16'd0);
    step();
    chk("R6 qualified", act_pins(), 16'(pins(3'd7)));

    // R8 drift guard off
    drift_en = 0; recal_in = 1; step(); step(); recal_in = 0;
    chk("R8 off", act_pins(), 16'(pins(3'd7)));
    chk("R8 no done", 16'(recal_done), 16'd0);

    // R7 recalibration
    drift_en = 1; recal_in = 1; lock_man = 0; step(); recal_in = 0;
    chk("R7 relock pins", act_pins(), 16'(pins(3'd0)));
    lock_man = 1; step();
    chk("R7 wait", 16'(st_locked), 16'd0);
    step();
    chk("R7 locked", act_pins(), 16'(pins(3'd7)));
    chk("R7 done", 16'(recal_done), 16'd1);
    step();
    chk("R7 done pulse", 16'(recal_done), 16'd0);

    // R9 deferred write during relock
    recal_in = 1; lock_man = 0; step(); recal_in = 0;
    wr(3'd5);
    chk("R9 mode now", 16'(mode_q), 16'd5);
    chk("R9 held", act_pins(), 16'(pins(3'd0)));
    lock_man = 1; step(); step();
    chk("R9 locked first", act_pins(), 16'(pins(3'd7)));
    chk("R9 done", 16'(recal_done), 16'd1);
    step();
    chk("R9 applied", act_pins(), 16'(pins(3'd5)));

    // R8 recal ignored in bypass
    wr(3'd6); recal_in = 1; step(); step(); recal_in = 0;
    chk("R8 bypass", act_pins(), 16'(pins(3'd6)));

    // R10 write and recal same cycle
    wr(3'd7); lock_up();
    chk("R10 setup", act_pins(), 16'(pins(3'd7)));
    mode_wdata = 3'd6; mode_wr = 1; recal_in = 1; step(); mode_wr = 0; recal_in = 0;
    chk("R10 write wins", act_pins(), 16'(pins(3'd6)));
    step();
    chk("R10 no done", 16'(recal_done), 16'd0);

    // R4 warm reset from locked
    wr(3'd7); lock_up(); warm();
    chk("R4 pins", act_pins(), 16'(pins(3'd4)));
    chk("R4 mode", 16'(mode_q), 16'd4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule